// File: doc/BRIEF.md
# Auto-Reload Upcounter with Update Control

This block is the counting core of a general-purpose timebase. A 16-bit counter advances by one on every qualified tick from an external prescaler. When it has reached the active reload limit, the next tick takes it back to zero and raises a one-cycle overflow pulse. Overflow, or a software request, produces an update event. The update event copies a staged reload limit into the active one and sets a sticky update flag. The flag stays set until software clears it.

Software controls the counter through level inputs and one-cycle strobes:

- an enable bit;
- a choice between immediate and staged reload writes;
- an update inhibit;
- a selector that keeps software updates from setting the flag;
- a one-shot mode that drops the enable at the update event;
- direct writes of the counter and the reload limit.

The enable reaches the counter one clock after it is written, through a registered run signal. The prescaler and the register decoding sit outside this block.

Top module: `reload_counter`

## Requirements
- R1: After synchronous reset the counter reads 0, `ovf_o`, `upd_o`, `flag_o` and `run_o` are 0, and the active and staged reload limits are all ones (0xFFFF), so a counter written to 0xFFFE wraps after two ticks.
- R2: While `run_o` is 1, each cycle with `tick_i` high adds one to the counter. A tick while the counter equals the active limit loads 0 instead. At that same edge `ovf_o` and `upd_o` rise for exactly one cycle and `flag_o` is set, so they are first seen together with the counter value 0.
- R3: `run_o` follows the stored enable one cycle later: it is high in the second cycle after an enable write of 1. Ticks have no effect on the counter while `run_o` is 0.
- R4: With `buf_en_i` = 0, a reload write becomes the active limit at the next edge.
- R5: With `buf_en_i` = 1, a reload write goes only to the staged limit. That value becomes active at the next update event, and the active limit does not change at any other time.
- R6: With `upd_dis_i` = 1, no update event happens: `upd_o` stays 0, the flag is not set and the active limit is kept. A wrap still returns the counter to 0 and pulses `ovf_o`, and `sw_upd_i` still clears the counter.
- R7: With `ovf_only_i` = 1, `sw_upd_i` still produces `upd_o` but does not set the flag. A wrap still sets the flag.
- R8: With `one_shot_i` = 1, an update event clears the stored enable and drops `run_o` at that same edge. After that the counter holds its value.
- R9: While the active limit is 0, ticks leave the counter unchanged and no overflow occurs.
- R10: `cnt_wr_i` loads `cnt_wdata_i` into the counter at the next edge, even while counting. Priority at one edge is `sw_upd_i` (clear to 0) over a counter write over a tick. A write or clear in the same cycle as a tick suppresses the wrap.
- R11: `flag_o` is sticky and is cleared only by `flag_clr_i`. If a set and a clear arrive in the same cycle, the set wins.
- R12: With `upd_dis_i` = 0, `sw_upd_i` clears the counter, pulses `upd_o`, loads the staged limit into the active limit and, subject to R7, sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescaler tick; counts when high and running |
| en_wr_i | input | 1 | Strobe: write the stored enable |
| en_val_i | input | 1 | Value written to the enable |
| buf_en_i | input | 1 | 1: reload writes are staged until an update event |
| upd_dis_i | input | 1 | 1: suppress update events |
| ovf_only_i | input | 1 | 1: only overflow sets the flag |
| one_shot_i | input | 1 | 1: drop the enable at the update event |
| sw_upd_i | input | 1 | Strobe: software update request |
| cnt_wr_i | input | 1 | Strobe: load the counter |
| cnt_wdata_i | input | CNT_W | Counter load value |
| arr_wr_i | input | 1 | Strobe: write the reload limit |
| arr_wdata_i | input | CNT_W | Reload limit write value |
| flag_clr_i | input | 1 | Strobe: clear the update flag |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | One-cycle overflow pulse |
| upd_o | output | 1 | One-cycle update event pulse |
| flag_o | output | 1 | Sticky update flag |
| run_o | output | 1 | Effective counter enable |

## Verification
The embedded properties check, on every cycle, several rules that hold at single edges:

- a wrap or a software clear leaves the counter at 0;
- a zero limit freezes the counter;
- an immediate reload write is active one edge later, and a staged limit holds until an update;
- the inhibit keeps `upd_o` low;
- the overflow-only selector keeps software updates from setting the flag;
- the flag stays set until it is cleared;
- one-shot mode drops `run_o` at its update.

Only the bench scenarios can show sequences that span many edges. These include the one-cycle lag of `run_o` after an enable write, the reset limit of 0xFFFF seen through a wrap, and a staged limit that takes effect only after the following wrap. The bench also covers the kept limit under the inhibit and the priority order among clear, write and tick. A seeded random phase compares every output on every cycle with a reference model built from the requirements.

// File: rtl/reload_counter_pkg.sv
package reload_counter_pkg;

    // counter next-state selection, highest priority first in pick_op
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // decoded consequences of one cycle's update sources
    typedef struct packed {
        logic upd;       // update event fires
        logic flag_set;  // sticky flag is set
        logic stop;      // one-shot drop of the enable
    } upd_dec_t;

    function automatic cnt_op_e pick_op(input logic clear, input logic load,
                                        input logic step);
        if (clear)     return OP_CLEAR;
        else if (load) return OP_LOAD;
        else if (step) return OP_STEP;
        else           return OP_HOLD;
    endfunction

    function automatic upd_dec_t decode_update(input logic wrap, input logic sw_req,
                                               input logic inhibit, input logic ovf_only,
                                               input logic one_shot);
        upd_dec_t d;
        d.upd      = (wrap | sw_req) & ~inhibit;
        d.flag_set = ~inhibit & (wrap | (sw_req & ~ovf_only));
        d.stop     = one_shot & d.upd;
        return d;
    endfunction

endpackage

// File: rtl/rc_reload_reg.sv
module rc_reload_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arr_wr_i,
    input  logic [W-1:0] arr_wdata_i,
    input  logic         buf_en_i,
    input  logic         upd_ev_i,
    output logic [W-1:0] arr_act_o
);
    localparam logic [W-1:0] RST_VAL = {W{1'b1}};

    logic [W-1:0] stage_q;
    logic [W-1:0] stage_nx;

    assign stage_nx = arr_wr_i ? arr_wdata_i : stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= RST_VAL;
            arr_act_o <= RST_VAL;
        end else begin
            stage_q <= stage_nx;
            if (arr_wr_i && !buf_en_i)
                arr_act_o <= arr_wdata_i;
            else if (upd_ev_i)
                arr_act_o <= stage_nx;
        end
    end

    // R4
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_wr_i && !buf_en_i) |=> (arr_act_o == $past(arr_wdata_i)));

    // R5
    staged_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_en_i && !upd_ev_i) |=> $stable(arr_act_o));

endmodule

// File: rtl/rc_count_core.sv
module rc_count_core
    import reload_counter_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic    step;
    logic    at_limit;
    cnt_op_e op;

    assign step     = tick_i & run_i & (limit_i != '0) & ~clr_i & ~ld_i;
    assign at_limit = (cnt_o == limit_i);
    assign wrap_o   = step & at_limit;
    assign op       = pick_op(clr_i, ld_i, step);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: cnt_o <= '0;
                OP_LOAD:  cnt_o <= ld_val_i;
                OP_STEP:  cnt_o <= at_limit ? '0 : cnt_o + 1'b1;
                default:  cnt_o <= cnt_o;
            endcase
        end
    end

    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_o == '0));

    // R9
    zero_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (limit_i == '0 && !clr_i && !ld_i) |=> $stable(cnt_o));

    // R10
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_o == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clr_i && !ld_i) |=> $stable(cnt_o));

endmodule

// File: rtl/rc_update_ctrl.sv
module rc_update_ctrl
    import reload_counter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wrap_i,
    input  logic sw_upd_i,
    input  logic upd_dis_i,
    input  logic ovf_only_i,
    input  logic one_shot_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    input  logic flag_clr_i,
    output logic upd_ev_o,
    output logic ovf_o,
    output logic upd_o,
    output logic flag_o,
    output logic run_o
);
    upd_dec_t dec;
    logic     en_q;

    assign dec      = decode_update(wrap_i, sw_upd_i, upd_dis_i, ovf_only_i, one_shot_i);
    assign upd_ev_o = dec.upd;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            run_o  <= 1'b0;
            ovf_o  <= 1'b0;
            upd_o  <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            ovf_o <= wrap_i;
            upd_o <= dec.upd;
            if (dec.stop)      en_q <= 1'b0;
            else if (en_wr_i)  en_q <= en_val_i;
            run_o <= dec.stop ? 1'b0 : en_q;
            if (dec.flag_set)  flag_o <= 1'b1;
            else if (flag_clr_i) flag_o <= 1'b0;
        end
    end

    // R6
    inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        upd_dis_i |=> !upd_o);

    // R7
    sw_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_only_i && sw_upd_i && !flag_o) |=> !flag_o);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !flag_clr_i) |=> flag_o);

    // R8
    one_shot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (one_shot_i && upd_ev_o) |=> !run_o);

endmodule

// File: rtl/reload_counter.sv
module reload_counter
    import reload_counter_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_val_i,
    input  logic             buf_en_i,
    input  logic             upd_dis_i,
    input  logic             ovf_only_i,
    input  logic             one_shot_i,
    input  logic             sw_upd_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             arr_wr_i,
    input  logic [CNT_W-1:0] arr_wdata_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o,
    output logic             upd_o,
    output logic             flag_o,
    output logic             run_o
);
    logic [CNT_W-1:0] limit;
    logic             wrap;
    logic             upd_ev;

    rc_reload_reg #(.W(CNT_W)) u_reload (
        .clk        (clk),
        .rst        (rst),
        .arr_wr_i   (arr_wr_i),
        .arr_wdata_i(arr_wdata_i),
        .buf_en_i   (buf_en_i),
        .upd_ev_i   (upd_ev),
        .arr_act_o  (limit)
    );

    rc_count_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .run_i   (run_o),
        .clr_i   (sw_upd_i),
        .ld_i    (cnt_wr_i),
        .ld_val_i(cnt_wdata_i),
        .limit_i (limit),
        .cnt_o   (cnt_o),
        .wrap_o  (wrap)
    );

    rc_update_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wrap_i    (wrap),
        .sw_upd_i  (sw_upd_i),
        .upd_dis_i (upd_dis_i),
        .ovf_only_i(ovf_only_i),
        .one_shot_i(one_shot_i),
        .en_wr_i   (en_wr_i),
        .en_val_i  (en_val_i),
        .flag_clr_i(flag_clr_i),
        .upd_ev_o  (upd_ev),
        .ovf_o     (ovf_o),
        .upd_o     (upd_o),
        .flag_o    (flag_o),
        .run_o     (run_o)
    );

    // R12
    sw_update_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_upd_i && !upd_dis_i) |=> (upd_o && cnt_o == '0));

endmodule

// File: tb/test_reload_counter.sv
module test_reload_counter;
    localparam int W = 16;
    localparam int MAX_CYC = 200000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_i = 0, en_wr_i = 0, en_val_i = 0, buf_en_i = 0;
    logic         upd_dis_i = 0, ovf_only_i = 0, one_shot_i = 0, sw_upd_i = 0;
    logic         cnt_wr_i = 0, arr_wr_i = 0, flag_clr_i = 0;
    logic [W-1:0] cnt_wdata_i = '0, arr_wdata_i = '0;
    logic [W-1:0] cnt_o;
    logic         ovf_o, upd_o, flag_o, run_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    logic [W-1:0] m_cnt, m_pre, m_sh;
    logic         m_en, m_run, m_ovf, m_upd, m_flag;

    always #10 clk = ~clk;

    reload_counter #(.CNT_W(W)) i_reload_counter (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_wr_i(en_wr_i), .en_val_i(en_val_i),
        .buf_en_i(buf_en_i), .upd_dis_i(upd_dis_i), .ovf_only_i(ovf_only_i),
        .one_shot_i(one_shot_i), .sw_upd_i(sw_upd_i), .cnt_wr_i(cnt_wr_i),
        .cnt_wdata_i(cnt_wdata_i), .arr_wr_i(arr_wr_i), .arr_wdata_i(arr_wdata_i),
        .flag_clr_i(flag_clr_i), .cnt_o(cnt_o), .ovf_o(ovf_o), .upd_o(upd_o),
        .flag_o(flag_o), .run_o(run_o)
    );

    // model written from the requirements (R2..R12)
    always @(posedge clk) begin
        logic adv, wrap, ev, setf, stop;
        logic [W-1:0] npre;
        cycles++;
        if (rst) begin
            m_cnt = '0; m_pre = '1; m_sh = '1;
            m_en = 0; m_run = 0; m_ovf = 0; m_upd = 0; m_flag = 0;
        end else begin
            adv  = tick_i && m_run && (m_sh != 0) && !sw_upd_i && !cnt_wr_i;
            wrap = adv && (m_cnt == m_sh);
            ev   = (wrap || sw_upd_i) && !upd_dis_i;
            setf = !upd_dis_i && (wrap || (sw_upd_i && !ovf_only_i));
            stop = one_shot_i && ev;
            if (sw_upd_i)      m_cnt = '0;
            else if (cnt_wr_i) m_cnt = cnt_wdata_i;
            else if (adv)      m_cnt = wrap ? '0 : m_cnt + 1'b1;
            npre = arr_wr_i ? arr_wdata_i : m_pre;
            if (arr_wr_i && !buf_en_i) m_sh = arr_wdata_i;
            else if (ev)               m_sh = npre;
            m_pre = npre;
            m_run = stop ? 1'b0 : m_en;
            if (stop)         m_en = 0;
            else if (en_wr_i) m_en = en_val_i;
            if (setf)            m_flag = 1;
            else if (flag_clr_i) m_flag = 0;
            m_ovf = wrap;
            m_upd = ev;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk("R2 model cnt", 32'(cnt_o), 32'(m_cnt));
        chk("R2 model pulses/flag/run", {ovf_o, upd_o, flag_o, run_o},
            {m_ovf, m_upd, m_flag, m_run});
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        en_wr_i = 0; sw_upd_i = 0; cnt_wr_i = 0; arr_wr_i = 0; flag_clr_i = 0;
        @(negedge clk);
        cmp_model();
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        wait (cycles >= MAX_CYC);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below %0d", cycles, MAX_CYC);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1 cnt", 32'(cnt_o), 0);
        chk("R1 outputs", {ovf_o, upd_o, flag_o, run_o}, 0);

        // R3 enable lag
        en_wr_i = 1; en_val_i = 1; tick_i = 1;
        cyc();
        chk("R3 run lag", 32'(run_o), 0);
        cyc();
        chk("R3 run high", 32'(run_o), 1);
        chk("R3 ticks ignored", 32'(cnt_o), 0);

        // R1 reset limit 0xFFFF, R10 load while running
        cnt_wr_i = 1; cnt_wdata_i = 16'hFFFE;
        cyc();
        chk("R10 load", 32'(cnt_o), 32'hFFFE);
        cyc();
        chk("R1 count to ffff", 32'(cnt_o), 32'hFFFF);
        cyc();
        chk("R1 wrap at ffff", {cnt_o, ovf_o, upd_o, flag_o}, {16'h0, 3'b111});

        // R4 immediate limit, R2 wrap, R11 clear
        tick_i = 0; arr_wr_i = 1; arr_wdata_i = 5;
        cyc();
        flag_clr_i = 1;
        cyc();
        chk("R11 clear", 32'(flag_o), 0);
        tick_i = 1;
        cycn(5);
        chk("R2 count", 32'(cnt_o), 5);
        cyc();
        chk("R2 R4 wrap", {cnt_o, ovf_o, upd_o, flag_o}, {16'h0, 3'b111});
        cyc();
        chk("R2 pulse one cycle", {cnt_o, ovf_o, upd_o}, {16'h1, 2'b00});
        chk("R11 sticky", 32'(flag_o), 1);

        // R11 set beats clear, R12 software update
        tick_i = 0; flag_clr_i = 1; sw_upd_i = 1;
        cyc();
        chk("R11 set wins", 32'(flag_o), 1);
        chk("R12 sw update", {cnt_o, upd_o}, {16'h0, 1'b1});

        // R5 staged limit
        buf_en_i = 1; arr_wr_i = 1; arr_wdata_i = 2;
        cyc();
        tick_i = 1;
        cycn(5);
        chk("R5 old limit kept", 32'(cnt_o), 5);
        cyc();
        chk("R5 wrap at old limit", {cnt_o, ovf_o}, {16'h0, 1'b1});
        cycn(3);
        chk("R5 new limit", {cnt_o, ovf_o}, {16'h0, 1'b1});
        tick_i = 0;

        // R6 inhibit
        upd_dis_i = 1; flag_clr_i = 1;
        cyc();
        arr_wr_i = 1; arr_wdata_i = 4;
        cyc();
        tick_i = 1;
        cycn(3);
        chk("R6 wrap no update", {cnt_o, ovf_o, upd_o, flag_o}, {16'h0, 3'b100});
        cyc();
        tick_i = 0; sw_upd_i = 1;
        cyc();
        chk("R6 sw clear no update", {cnt_o, upd_o}, {16'h0, 1'b0});
        upd_dis_i = 0; tick_i = 1;
        cycn(3);
        chk("R6 limit kept", {cnt_o, ovf_o, upd_o, flag_o}, {16'h0, 3'b111});
        tick_i = 0;

        // R7 overflow-only flag
        flag_clr_i = 1;
        cyc();
        ovf_only_i = 1; sw_upd_i = 1;
        cyc();
        chk("R7 sw no flag", {upd_o, flag_o}, 2'b10);
        tick_i = 1;
        cycn(5);
        chk("R7 wrap sets flag", {cnt_o, ovf_o, flag_o}, {16'h0, 2'b11});
        ovf_only_i = 0;

        // R10 priority
        cnt_wr_i = 1; cnt_wdata_i = 3; sw_upd_i = 1;
        cyc();
        chk("R10 clear over load", 32'(cnt_o), 0);
        cnt_wr_i = 1; cnt_wdata_i = 3;
        cyc();
        chk("R10 load over tick", 32'(cnt_o), 3);
        cyc();
        chk("R10 counts on", 32'(cnt_o), 4);
        tick_i = 0;

        // R9 zero limit blocks
        buf_en_i = 0; arr_wr_i = 1; arr_wdata_i = 0; cnt_wr_i = 1; cnt_wdata_i = 2;
        cyc();
        tick_i = 1;
        cycn(4);
        chk("R9 blocked", {cnt_o, ovf_o}, {16'h2, 1'b0});
        tick_i = 0;

        // R8 one-shot
        arr_wr_i = 1; arr_wdata_i = 3; cnt_wr_i = 1; cnt_wdata_i = 0;
        cyc();
        one_shot_i = 1; tick_i = 1;
        cycn(4);
        chk("R8 stop at update", {cnt_o, upd_o, run_o}, {16'h0, 2'b10});
        cycn(3);
        chk("R8 held", {cnt_o, run_o}, {16'h0, 1'b0});
        one_shot_i = 0; tick_i = 0;
        en_wr_i = 1; en_val_i = 1;
        cycn(2);
        chk("R3 restart", 32'(run_o), 1);

        // seeded random phase against the model
        for (int n = 0; n < 4000; n++) begin
            tick_i      = ($urandom % 10) < 7;
            en_wr_i     = ($urandom % 20) == 0;
            en_val_i    = ($urandom % 5) != 0;
            if (($urandom % 20) == 0) buf_en_i = ~buf_en_i;
            upd_dis_i   = ($urandom % 10) == 0;
            ovf_only_i  = ($urandom % 2) == 0;
            one_shot_i  = ($urandom % 10) == 0;
            sw_upd_i    = ($urandom % 30) == 0;
            cnt_wr_i    = ($urandom % 30) == 0;
            cnt_wdata_i = W'($urandom % 8);
            arr_wr_i    = ($urandom % 25) == 0;
            arr_wdata_i = W'($urandom % 10);
            flag_clr_i  = ($urandom % 10) == 0;
            cyc();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule